// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM Array

This block is a clocked single-port memory of 32-bit words. Every input, including address, write data and all control, is captured on the rising clock edge. A captured read returns its word in the same cycle that follows the capturing edge, with no further register on the read path. A captured write is committed on the next edge.

Writes reach the four bytes of a word along two paths. Per-byte strobes take effect only while a byte-write enable is asserted. A global write overrides them and stores the whole word. Three select inputs of mixed polarity must all agree before any cycle is accepted.

A sleep input powers the array down. When sleep is released, a fixed number of wake-up edges pass with nothing accepted before service resumes. The read strobe depends on an asynchronous output enable and stands in for a high-impedance pad.

Top module: `sync_bw_sram`

## Requirements
- R1: Inputs are sampled on the rising edge. A write accepted at edge k is seen by a read accepted at edge k+1. The read word appears on `rdata` with `rvalid` high during the cycle that directly follows its capturing edge.
- R2: The active-low byte strobes map lanes as follows: `be_n[0]` to bits 7:0, `be_n[1]` to 15:8, `be_n[2]` to 23:16 and `be_n[3]` to 31:24. While `bwe_n` is low, each low strobe writes its lane and each high strobe leaves its lane unchanged.
- R3: While `bwe_n` and `gwe_n` are both high, the strobes are ignored and an accepted cycle is a read. A cycle with `bwe_n` low and all four strobes high is also a read.
- R4: A low `gwe_n` writes all four lanes whatever `bwe_n` and `be_n` are.
- R5: A cycle is accepted only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. Otherwise it writes nothing and `rvalid` stays low in the following cycle.
- R6: `rvalid` is high only when an accepted read was captured and `oe_n` is low. `oe_n` acts without a clock. `rdata` is zero whenever `rvalid` is low.
- R7: An edge that samples `sleep` high accepts nothing. So do the first three edges after that which sample `sleep` low. The fourth such edge is accepted again. `rvalid` is low while `sleep` is high.
- R8: A write accepted on the edge just before `sleep` is raised is still committed.
- R9: After reset, `rvalid` is low, `rdata` is zero, no write is pending and the array is awake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| gwe_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies `be_n` |
| be_n | input | NL | Per-lane write strobes, active low |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DW | Read word, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
A write can be in flight, waiting to commit, on the same edge that first samples `sleep` high. The bench provokes this by issuing a write and raising `sleep` in the very next cycle. It then tries further writes during power-down and wake-up, and judges the outcome by a read after wake-up: that read must return the pre-sleep write and none of the later attempts. The same run checks that reads during the wake-up edges stay invalid and that the fourth edge is served.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sbw_power.sv
module sbw_power #(
  parameter int WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic ready
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wake_cnt <= '0;
    else if (sleep)           wake_cnt <= CW'(WAKE_CYC);
    else if (wake_cnt != '0)  wake_cnt <= wake_cnt - CW'(1);
  end

  assign ready = !sleep && (wake_cnt == '0);

  AST_SLEEP_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !ready); // R7
endmodule

// File: rtl/sbw_capture.sv
module sbw_capture
  import sbw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NL = DW / LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          gwe_n,
  input  logic          bwe_n,
  input  logic [NL-1:0] be_n,
  input  logic          ready,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [NL-1:0] mask_q
);
  // lane mask of a cycle: global write wins, else strobes when qualified
  function automatic logic [NL-1:0] lane_mask(input logic g_n, input logic b_n,
                                               input logic [NL-1:0] s_n);
    if (!g_n)      return '1;
    else if (!b_n) return ~s_n;
    else           return '0;
  endfunction

  logic          sel_hit;
  logic          accept;
  logic [NL-1:0] mask_now;

  assign sel_hit  = !sel_a_n && sel_b && !sel_c_n;
  assign accept   = sel_hit && ready;
  assign mask_now = lane_mask(gwe_n, bwe_n, be_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (!accept)           op_q <= OP_IDLE;
      else if (|mask_now)    op_q <= OP_WRITE;
      else                   op_q <= OP_READ;
      mask_q  <= accept ? mask_now : '0;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |=> (op_q == OP_IDLE)); // R5
  AST_GLOBAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gwe_n) |=> (mask_q == '1)); // R4
  AST_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && gwe_n && bwe_n) |=> (op_q == OP_READ)); // R3
endmodule

// File: rtl/sbw_array.sv
module sbw_array
  import sbw_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int NL    = DW / LANE_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [NL-1:0] mask,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  for (genvar ln = 0; ln < NL; ln++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && mask[ln]) cells[addr] <= wdata[ln*LANE_W +: LANE_W];
    end

    assign rdata[ln*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/sync_bw_sram.sv
module sync_bw_sram
  import sbw_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int DW       = 32,
  parameter int WAKE_CYC = 3,
  localparam int AW      = $clog2(DEPTH),
  localparam int NL      = DW / LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          gwe_n,
  input  logic          bwe_n,
  input  logic [NL-1:0] be_n,
  input  logic          sleep,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          ready;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NL-1:0] mask_q;
  logic [DW-1:0] arr_rd;
  logic          wr_go;

  sbw_power #(.WAKE_CYC(WAKE_CYC)) u_power (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ready(ready)
  );

  sbw_capture #(.AW(AW), .DW(DW), .NL(NL)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .wdata(wdata), .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n),
    .ready(ready),
    .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q)
  );

  // a captured write commits on the next edge, independent of sleep
  assign wr_go = (op_q == OP_WRITE);

  sbw_array #(.AW(AW), .DEPTH(DEPTH), .DW(DW), .NL(NL)) u_array (
    .clk(clk), .we(wr_go), .mask(mask_q), .addr(addr_q),
    .wdata(wdata_q), .rdata(arr_rd)
  );

  assign rvalid = (op_q == OP_READ) && !oe_n && !sleep;
  assign rdata  = rvalid ? arr_rd : '0;

  AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !rvalid); // R7
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwe_n && !sel_a_n && sel_b && !sel_c_n) |=> !rvalid); // R6
endmodule

// File: tb/sim_sync_bw_sram.sv
module sim_sync_bw_sram;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  typedef struct {
    logic        v;
    logic [31:0] d;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sel_a_n = 1, sel_b = 0, sel_c_n = 1;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        gwe_n = 1, bwe_n = 1;
  logic [3:0]  be_n = 4'hF;
  logic        sleep = 0, oe_n = 0;
  logic [31:0] rdata;
  logic        rvalid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t sb[$];
  logic [31:0] mdl [int];
  int wake = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_bw_sram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .wdata(wdata), .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n),
    .sleep(sleep), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  // driver: one cycle, expectation derived from the requirements
  task automatic cyc(input logic a_n, input logic b, input logic c_n,
                     input int ad, input logic [31:0] d, input logic g_n,
                     input logic bw_n, input logic [3:0] s_n, input logic sl,
                     input logic oe, input string tag);
    exp_t e;
    logic ok;
    logic [3:0] m;
    logic [31:0] w;
    @(negedge clk);
    sel_a_n = a_n; sel_b = b; sel_c_n = c_n; addr = AW'(ad); wdata = d;
    gwe_n = g_n; bwe_n = bw_n; be_n = s_n; sleep = sl; oe_n = oe;
    ok = !a_n && b && !c_n && !sl && (wake == 0);          // R5 R7
    m  = !g_n ? 4'hF : (!bw_n ? ~s_n : 4'h0);              // R2 R3 R4
    e.tag = tag;
    e.v = ok && (m == 0) && !oe;                            // R6
    e.d = e.v ? mdl[ad] : 32'h0;
    if (ok && m != 0) begin
      w = mdl.exists(ad) ? mdl[ad] : 32'h0;
      for (int i = 0; i < 4; i++) if (m[i]) w[i*8 +: 8] = d[i*8 +: 8];
      mdl[ad] = w;
    end
    if (sl) wake = 3; else if (wake > 0) wake--;
    sb.push_back(e);
  endtask

  task automatic wr_g(input int ad, input logic [31:0] d, input string tag);
    cyc(0, 1, 0, ad, d, 0, 1, 4'hF, 0, 0, tag);
  endtask
  task automatic wr_b(input int ad, input logic [31:0] d, input logic [3:0] s_n,
                      input string tag);
    cyc(0, 1, 0, ad, d, 1, 0, s_n, 0, 0, tag);
  endtask
  task automatic rd(input int ad, input string tag);
    cyc(0, 1, 0, ad, 32'h0, 1, 1, 4'hF, 0, 0, tag);
  endtask

  // monitor: compares every cycle a quarter period after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_cmp++;
        if (rvalid !== e.v || rdata !== e.d) begin
          n_bad++;
          $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                   e.tag, rvalid, rdata, e.v, e.d);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    n_cmp++;
    if (rvalid !== 1'b0 || rdata !== 32'h0) begin  // R9
      n_bad++;
      $display("FAIL R9: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
    end
    @(negedge clk); rst_n = 1;

    // R1 R4: global write then immediate read
    wr_g(0, 32'hDEADBEEF, "R4");
    rd(0, "R1");
    // R2: single lanes
    wr_b(0, 32'h11223344, 4'b1110, "R2");
    rd(0, "R2");
    wr_b(0, 32'hAA000000, 4'b0111, "R2");
    rd(0, "R2");
    wr_b(0, 32'h00CCDD00, 4'b1001, "R2");
    rd(0, "R2");
    // R3: strobes low but byte-write enable off is a read
    cyc(0, 1, 0, 0, 32'h0, 1, 1, 4'h0, 0, 0, "R3");
    cyc(0, 1, 0, 0, 32'h0, 1, 0, 4'hF, 0, 0, "R3");
    // R4: global overrides strobes all high
    cyc(0, 1, 0, 1, 32'hCAFEF00D, 0, 0, 4'hF, 0, 0, "R4");
    rd(1, "R4");
    // R5: each select wrong, write attempt then read attempt
    cyc(1, 1, 0, 1, 32'h0, 0, 1, 4'hF, 0, 0, "R5");
    cyc(0, 0, 0, 1, 32'h0, 0, 1, 4'hF, 0, 0, "R5");
    cyc(0, 1, 1, 1, 32'h0, 0, 1, 4'hF, 0, 0, "R5");
    cyc(1, 1, 0, 1, 32'h0, 1, 1, 4'hF, 0, 0, "R5");
    rd(1, "R5");
    // R6: output enable off hides a read
    cyc(0, 1, 0, 1, 32'h0, 1, 1, 4'hF, 0, 1, "R6");
    rd(1, "R6");
    // R7 R8: write, then sleep on the very next edge
    wr_g(2, 32'h0BADF00D, "R8");
    wr_g(3, 32'h5555AAAA, "R8");
    cyc(0, 1, 0, 3, 32'h12345678, 0, 1, 4'hF, 1, 0, "R7");
    cyc(0, 1, 0, 2, 32'h0, 1, 1, 4'hF, 1, 0, "R7");
    cyc(0, 1, 0, 2, 32'hFFFFFFFF, 0, 1, 4'hF, 0, 0, "R7");
    rd(3, "R7");
    rd(2, "R7");
    rd(3, "R7");
    rd(3, "R8");
    rd(2, "R7");
    // R1: back-to-back at the top address
    wr_g(DEPTH-1, 32'h01020304, "R1");
    rd(DEPTH-1, "R1");
    wr_b(DEPTH-1, 32'hF0F0F0F0, 4'b0101, "R2");
    rd(DEPTH-1, "R2");
    rd(0, "R1");
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule